// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a programmable interval timer. It holds a 16-bit reload value, counts elapsed input ticks from the moment the value is loaded or the count is restarted, and drives one output line with one of six waveforms: a terminal-count flag, a retriggerable one-shot, a rate generator, a square wave, and two single-tick strobes. The channel runs on the system clock. Counting advances only in cycles where the single-cycle `tickEn` input is high, so any slower count rate can be produced by a divider outside the block.

A register front end, which is not part of this block, supplies a mode code through a write strobe and a reload value through a load strobe. The channel shows its live count on `countOut` and its waveform on `outLevel`. The gate input either suspends counting or restarts it on a rising edge, depending on the mode. The parameter `CHAN_IDX` picks the level the gate is assumed to have held before reset. Channel 2 assumes low and the others assume high, so a gate that is high when reset is released restarts channel 2 but not the others.

Top module: `pit_chan_top`

## Requirements
- R1: A loaded value of 0 stands for 65536 ticks. `countOut` reads 0 after the load, reads 0xFFFF after one tick, and in mode 0 `outLevel` rises only after the 65536th tick.
- R2: Mode code 0 (terminal flag): `outLevel` is low after a load and goes high once the elapsed ticks reach the reload value N. It then stays high. `countOut` shows (N - ticks) modulo 65536 and keeps wrapping after terminal count.
- R3: Mode code 1 (one-shot): `outLevel` is high while the elapsed ticks are below N and low from then on. `countOut` shows (N - ticks) modulo 65536.
- R4: Mode code 2 (rate generator): `outLevel` is high for exactly one tick period each time the elapsed ticks reach a nonzero multiple of N. `countOut` shows N minus (ticks mod N), so it reloads to N automatically.
- R5: Mode code 3 (square wave): with p = ticks mod N, `outLevel` is high while p < (N+1)/2 and low for the rest of the period. For odd N the high phase is the longer one.
- R6: In mode code 3, `countOut` shows N - ((2·p) mod N), so it falls by two per tick.
- R7: Mode codes 4 and 5 (strobes): `outLevel` is high for the single tick period in which the elapsed ticks equal N, and low before and after it. `countOut` behaves as in R2.
- R8: In mode codes 1, 2, 3, 5, 6 and 7, a rising edge on `gateIn` restarts counting from the full reload value: elapsed ticks return to 0 and `countOut` returns to N.
- R9: In mode codes 0 and 4, a low `gateIn` suspends counting and does not reload. Ticks are ignored and `countOut` and `outLevel` hold until the gate is high again.
- R10: Mode codes 6 and 7 behave exactly like mode codes 2 and 3.
- R11: After reset the channel is in mode code 3 with N = 65536, `countOut` reads 0 and `outLevel` is high. A rising gate edge is detected in the first clock after reset only when `CHAN_IDX` is 2.
- R12: `countOut` and `outLevel` change only because of a tick, a load, a mode write or a gate edge. With none of these they hold.
- R13: A mode write restarts counting from the current reload value. A load takes priority over a mode-write restart and over a gate restart, and a restart takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count enable; each high cycle is one input tick |
| gateIn | input | 1 | Gate level: enables counting or triggers a restart, depending on mode |
| loadStrobe | input | 1 | Loads `loadValue` as the new reload value and restarts the count |
| loadValue | input | 16 | Reload value; 0 means 65536 |
| modeWr | input | 1 | Writes `modeCode` and restarts the count |
| modeCode | input | 3 | Operating mode, 0 to 7 |
| countOut | output | 16 | Live count |
| outLevel | output | 1 | Waveform output |

## Verification
The bound checker applies five properties on every cycle. Loaded values appear on the count in the next cycle, zero loads read back as 0, outputs hold in idle cycles, the mode 0 flag never drops without a reload or mode change, and the mode 4/5 strobe lasts only one tick. Everything that depends on how many ticks have elapsed can only be shown by the directed scenarios. That covers the mode 2 pulse position, the mode 3 duty split and step-by-two count for odd and even N, the 65536-tick run for a zero load, gate suspend and retrigger, and the reset gate default that separates channel 2 from the others.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  // Strobes from the control half to the datapath half, one cycle each
  typedef struct packed {
    logic reload;    // take loadValue as new reload value and restart
    logic restart;   // restart from the stored reload value
    logic advance;   // count one tick
    logic periodic;  // wrap the phase at the reload value
  } chanStrobe_t;

  localparam logic [2:0] MODE_RESET = 3'd3;

endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
#(
  parameter bit GATE_RST = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        gateIn,
  input  logic        loadStrobe,
  input  logic        modeWr,
  input  logic [2:0]  modeCode,
  output chanStrobe_t strobe,
  output logic [2:0]  modeEff
);

  logic [2:0] modeReg;
  logic       gatePrev;
  logic       gateRise;
  logic       gateHolds;   // gate level suspends counting
  logic       gateRetrig;  // gate edge restarts counting
  logic       restartNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_RESET;
      gatePrev <= GATE_RST;
    end else begin
      gatePrev <= gateIn;
      if (modeWr) modeReg <= modeCode;
    end
  end

  // codes 6 and 7 fold onto 2 and 3
  assign modeEff    = {modeReg[2] & ~modeReg[1], modeReg[1:0]};
  assign gateRise   = gateIn & ~gatePrev;
  assign gateHolds  = (modeEff == 3'd0) || (modeEff == 3'd4);
  assign gateRetrig = !gateHolds;
  assign restartNow = !loadStrobe && (modeWr || (gateRise && gateRetrig));

  always_comb begin
    strobe          = '0;
    strobe.reload   = loadStrobe;
    strobe.restart  = restartNow;
    strobe.advance  = tickEn && !loadStrobe && !restartNow && (!gateHolds || gateIn);
    strobe.periodic = modeReg[1];
  end

endmodule

// File: rtl/pit_chan_datapath.sv
module pit_chan_datapath
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic [CNT_W-1:0]  loadValue,
  output logic [CNT_W:0]    reloadVal,
  output logic [CNT_W:0]    phase,
  output logic              started,
  output logic              pastTerm,
  output logic [CNT_W-1:0]  downCnt
);

  localparam int PW = CNT_W + 1;
  localparam logic [PW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] loadN;
  logic [PW-1:0] phaseInc;

  assign loadN    = (loadValue == '0) ? FULL : {1'b0, loadValue};
  assign phaseInc = phase + ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= FULL;
      phase     <= '0;
      started   <= 1'b0;
      pastTerm  <= 1'b0;
      downCnt   <= '0;
    end else if (strobe.reload) begin
      reloadVal <= loadN;
      phase     <= '0;
      started   <= 1'b0;
      pastTerm  <= 1'b0;
      downCnt   <= loadValue;
    end else if (strobe.restart) begin
      phase     <= '0;
      started   <= 1'b0;
      pastTerm  <= 1'b0;
      downCnt   <= reloadVal[CNT_W-1:0];
    end else if (strobe.advance) begin
      started <= 1'b1;
      downCnt <= downCnt - 1'b1;
      if (strobe.periodic) begin
        phase <= (phaseInc == reloadVal) ? '0 : phaseInc;
      end else if (phase == reloadVal) begin
        pastTerm <= 1'b1;
      end else begin
        phase <= phaseInc;
      end
    end
  end

endmodule

// File: rtl/pit_chan_wave.sv
module pit_chan_wave #(
  parameter int CNT_W = 16
) (
  input  logic [2:0]        modeEff,
  input  logic [CNT_W:0]    reloadVal,
  input  logic [CNT_W:0]    phase,
  input  logic              started,
  input  logic              pastTerm,
  input  logic [CNT_W-1:0]  downCnt,
  output logic [CNT_W-1:0]  countOut,
  output logic              outLevel
);

  localparam int EW = CNT_W + 2;

  logic [EW-1:0] nExt;
  logic [EW-1:0] pExt;
  logic [EW-1:0] halfHi;
  logic [EW-1:0] dbl;
  logic [EW-1:0] fold;
  logic          termHit;

  assign nExt    = {1'b0, reloadVal};
  assign pExt    = {1'b0, phase};
  assign halfHi  = (nExt + EW'(1)) >> 1;
  assign dbl     = {phase, 1'b0};
  assign fold    = (dbl >= nExt) ? (dbl - nExt) : dbl;
  assign termHit = (phase == reloadVal);

  always_comb begin
    countOut = downCnt;
    outLevel = 1'b0;
    case (modeEff)
      3'd0: outLevel = termHit;
      3'd1: outLevel = !termHit;
      3'd2: begin
        outLevel = (phase == '0) && started;
        countOut = CNT_W'(nExt - pExt);
      end
      3'd3: begin
        outLevel = (pExt < halfHi);
        countOut = CNT_W'(nExt - fold);
      end
      default: outLevel = termHit && !pastTerm;
    endcase
  end

endmodule

// File: rtl/pit_chan_top.sv
module pit_chan_top
  import pit_chan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gateIn,
  input  logic              loadStrobe,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic              modeWr,
  input  logic [2:0]        modeCode,
  output logic [CNT_W-1:0]  countOut,
  output logic              outLevel
);

  localparam bit GATE_RST = (CHAN_IDX != 2);

  chanStrobe_t      strobe;
  logic [2:0]       modeEff;
  logic [CNT_W:0]   reloadVal;
  logic [CNT_W:0]   phase;
  logic             started;
  logic             pastTerm;
  logic [CNT_W-1:0] downCnt;

  pit_chan_ctrl #(.GATE_RST(GATE_RST)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .gateIn     (gateIn),
    .loadStrobe (loadStrobe),
    .modeWr     (modeWr),
    .modeCode   (modeCode),
    .strobe     (strobe),
    .modeEff    (modeEff)
  );

  pit_chan_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadValue (loadValue),
    .reloadVal (reloadVal),
    .phase     (phase),
    .started   (started),
    .pastTerm  (pastTerm),
    .downCnt   (downCnt)
  );

  pit_chan_wave #(.CNT_W(CNT_W)) wave_i (
    .modeEff   (modeEff),
    .reloadVal (reloadVal),
    .phase     (phase),
    .started   (started),
    .pastTerm  (pastTerm),
    .downCnt   (downCnt),
    .countOut  (countOut),
    .outLevel  (outLevel)
  );

endmodule

// File: rtl/pit_chan_checker.sv
module pit_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             gateIn,
  input logic             loadStrobe,
  input logic [CNT_W-1:0] loadValue,
  input logic             modeWr,
  input logic [2:0]       modeCode,
  input logic [CNT_W-1:0] countOut,
  input logic             outLevel
);

  logic [2:0] modeSeen;

  always_ff @(posedge clk) begin
    if (!rstN)       modeSeen <= 3'd3;
    else if (modeWr) modeSeen <= modeCode;
  end

  // R1: zero load reads back as 0 on the next cycle
  p_zero_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && (loadValue == '0) |=> (countOut == '0));

  // R13: any nonzero load appears on the count next cycle in every mode
  p_load_visible_r13: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && (loadValue != '0) |=> (countOut == $past(loadValue)));

  // R12: no tick, load, mode write or possible gate edge -> outputs hold
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !loadStrobe && !modeWr && !gateIn |=>
      $stable(countOut) && $stable(outLevel));

  // R2: terminal flag in mode 0 stays high until a load or mode write
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeen == 3'd0) && outLevel && !loadStrobe && !modeWr |=> outLevel);

  // R7: strobe in modes 4/5 lasts one tick
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSeen == 3'd4) || (modeSeen == 3'd5)) && outLevel && tickEn && gateIn
      && !loadStrobe && !modeWr |=> !outLevel);

endmodule

bind pit_chan_top pit_chan_checker #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .gateIn     (gateIn),
  .loadStrobe (loadStrobe),
  .loadValue  (loadValue),
  .modeWr     (modeWr),
  .modeCode   (modeCode),
  .countOut   (countOut),
  .outLevel   (outLevel)
);

// File: tb/pit_chan_top_tb_top.sv
`timescale 1ns/1ps
module pit_chan_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gateIn = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [15:0] loadValue = '0;
  logic        modeWr = 1'b0;
  logic [2:0]  modeCode = '0;
  logic [15:0] countOut, countOut2;
  logic        outLevel, outLevel2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pit_chan_top #(.CNT_W(16), .CHAN_IDX(0)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .modeWr(modeWr),
    .modeCode(modeCode), .countOut(countOut), .outLevel(outLevel));

  pit_chan_top #(.CNT_W(16), .CHAN_IDX(2)) dut2_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .modeWr(modeWr),
    .modeCode(modeCode), .countOut(countOut2), .outLevel(outLevel2));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic st(input string tag, input int c, input bit o);
    chk({tag, " count"}, int'(countOut), c);
    chk({tag, " out"}, int'(outLevel), int'(o));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1; @(negedge clk); tickEn = 1'b0; @(negedge clk);
    end
  endtask

  task automatic load(input int v);
    loadStrobe = 1'b1; loadValue = 16'(v); @(negedge clk); loadStrobe = 1'b0;
  endtask

  task automatic setMode(input int m);
    modeWr = 1'b1; modeCode = 3'(m); @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic gatePulseLowHigh();
    gateIn = 1'b0; @(negedge clk); gateIn = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    st("R11 in reset", 0, 1'b1);
    // release reset together with a tick while gate is high
    rstN = 1'b1; tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
    chk("R11 ch0 no restart, R6 step 2", int'(countOut), 16'hFFFE);
    chk("R11 ch2 gate edge restart", int'(countOut2), 0);
    chk("R11 ch0 mode3 out", int'(outLevel), 1);
  endtask

  task automatic t_mode0();
    setMode(0); load(5);
    st("R2 after load", 5, 1'b0);
    ticks(4); st("R2 before term", 1, 1'b0);
    ticks(1); st("R2 at term", 0, 1'b1);
    ticks(1); st("R2 after term wraps", 16'hFFFF, 1'b1);
    repeat (10) @(negedge clk);
    st("R12 idle hold", 16'hFFFF, 1'b1);
  endtask

  task automatic t_zero();
    setMode(0); load(0);
    st("R1 zero load", 0, 1'b0);
    ticks(1); st("R1 first tick", 16'hFFFF, 1'b0);
    tickEn = 1'b1; repeat (65534) @(negedge clk); tickEn = 1'b0;
    st("R1 one before 65536", 1, 1'b0);
    ticks(1); st("R1 at 65536", 0, 1'b1);
  endtask

  task automatic t_suspend();
    setMode(0); load(5);
    gateIn = 1'b0; ticks(3);
    st("R9 mode0 gate low", 5, 1'b0);
    gateIn = 1'b1; @(negedge clk);
    st("R9 mode0 gate rise no reload", 5, 1'b0);
    ticks(5); st("R9 mode0 resumed", 0, 1'b1);
    setMode(4); load(3);
    gateIn = 1'b0; ticks(2);
    st("R9 mode4 gate low", 3, 1'b0);
    gateIn = 1'b1; @(negedge clk);
    ticks(3); st("R9 mode4 resumed strobe", 0, 1'b1);
  endtask

  task automatic t_mode1();
    setMode(1); load(3);
    st("R3 after load", 3, 1'b1);
    ticks(2); st("R3 mid", 1, 1'b1);
    ticks(1); st("R3 at term", 0, 1'b0);
    ticks(1); st("R3 after term", 16'hFFFF, 1'b0);
    gatePulseLowHigh();
    st("R8 mode1 retrigger", 3, 1'b1);
  endtask

  task automatic t_mode2(input int m, input string tag);
    setMode(m); load(3);
    st({tag, " load"}, 3, 1'b0);
    ticks(1); st({tag, " t1"}, 2, 1'b0);
    ticks(1); st({tag, " t2"}, 1, 1'b0);
    ticks(1); st({tag, " t3 pulse"}, 3, 1'b1);
    ticks(1); st({tag, " t4"}, 2, 1'b0);
    ticks(2); st({tag, " t6 pulse"}, 3, 1'b1);
  endtask

  task automatic t_mode2_gate();
    setMode(2); load(4);
    ticks(2); st("R8 mode2 mid", 2, 1'b0);
    gatePulseLowHigh();
    st("R8 mode2 restart", 4, 1'b0);
    ticks(4); st("R8 mode2 full period after restart", 4, 1'b1);
  endtask

  task automatic t_mode3_even();
    setMode(3); load(4);
    st("R5 N4 p0", 4, 1'b1);
    ticks(1); st("R6 N4 p1", 2, 1'b1);
    ticks(1); st("R5 N4 p2", 4, 1'b0);
    ticks(1); st("R6 N4 p3", 2, 1'b0);
    ticks(1); st("R5 N4 wrap", 4, 1'b1);
  endtask

  task automatic t_mode3_odd(input int m, input string tag);
    setMode(m); load(5);
    st({tag, " N5 p0"}, 5, 1'b1);
    ticks(1); st({tag, " N5 p1"}, 3, 1'b1);
    ticks(1); st({tag, " N5 p2"}, 1, 1'b1);
    ticks(1); st({tag, " N5 p3"}, 4, 1'b0);
    ticks(1); st({tag, " N5 p4"}, 2, 1'b0);
    ticks(1); st({tag, " N5 wrap"}, 5, 1'b1);
  endtask

  task automatic t_strobe();
    setMode(4); load(2);
    st("R7 m4 load", 2, 1'b0);
    ticks(1); st("R7 m4 t1", 1, 1'b0);
    ticks(1); st("R7 m4 strobe", 0, 1'b1);
    ticks(1); st("R7 m4 after", 16'hFFFF, 1'b0);
    ticks(3); st("R7 m4 no more", 16'hFFFC, 1'b0);
    setMode(5); load(2);
    ticks(2); st("R7 m5 strobe", 0, 1'b1);
    ticks(1); st("R7 m5 after", 16'hFFFF, 1'b0);
    gatePulseLowHigh();
    st("R8 mode5 retrigger", 2, 1'b0);
    ticks(2); st("R8 mode5 second strobe", 0, 1'b1);
  endtask

  task automatic t_modewr();
    setMode(2); load(6);
    ticks(2); st("R13 before mode write", 4, 1'b0);
    setMode(2); st("R13 mode write restarts", 6, 1'b0);
    // load and tick in the same cycle: load wins
    tickEn = 1'b1; load(7); tickEn = 1'b0;
    st("R13 load beats tick", 7, 1'b0);
  endtask

  initial begin : wd
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL R12 watchdog: actual %0d cycles expected below 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mode0();
    t_zero();
    t_suspend();
    t_mode1();
    t_mode2(2, "R4");
    t_mode2(6, "R10 m6");
    t_mode2_gate();
    t_mode3_even();
    t_mode3_odd(3, "R5 R6");
    t_mode3_odd(7, "R10 m7");
    t_strobe();
    t_modewr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule